// File: doc/BRIEF.md
# PSK Carrier Phase Error Folder

This block takes an 8-bit phase sample, where the full code range spans one turn of the circle, and strips the phase-shift-keying modulation from it. The carrier phase error that remains is folded into an arc centred on zero. Each accepted sample is rotated by a programmable offset and then multiplied by a programmable power of two. All arithmetic wraps modulo one turn.

The offset is a signed 4-bit value in steps of one sixteenth of a turn (22.5°). It is added to the upper nibble of the phase only. The multiplier is a left shift of 0 to 3 places that drops the bits pushed out at the top and fills zeros at the bottom. The result is a registered signed angle with a valid flag, which a carrier loop filter can use directly.

Typical settings by modulation order:

| Modulation | Offset | Shift |
|---|---|---|
| BPSK | 0 | 1 |
| QPSK | +2 (+45°) | 2 |
| 8-PSK | +1 (+22.5°) | 3 |

A shift of 0 applies the offset only.

Top module: `psk_phase_folder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `err_vld` and `err_out` are 0 after that edge.
- R2: `err_vld` is high in the cycle after a cycle with `phase_vld` high, and low in the cycle after a cycle with `phase_vld` low (one cycle of latency).
- R3: The offset `cfg_in[3:0]`, read as a two's complement count of 22.5° steps, is added modulo 16 to `phase_in[7:4]`. Bits `[3:0]` of the phase pass through the addition unchanged, and the carry out of bit 7 is lost. With shift 0 the output is this rotated phase.
- R4: The shift count `cfg_in[5:4]` (0 to 3) moves the rotated phase left by that many places. The top bits are discarded and zeros fill the low bits, so the low `cfg_in[5:4]` bits of `err_out` are 0.
- R5: A negative offset wraps below zero. For example, offset 4'hF with phase 8'h05 and shift 0 gives 8'hF5.
- R6: With QPSK settings (offset 2, shift 2), a phase of 8'h60 gives 8'h00, and a phase of 8'h65 gives 8'h14. Over all phases, the output equals ((phase + 32) × 4) mod 256.
- R7: `cfg_in` is read only together with an accepted sample. When `phase_vld` is low, changes on `cfg_in` or `phase_in` leave `err_out` holding its last value.
- R8: The output is the signed angle error, with 8'h80 standing for −180° and 8'h7F just below +180°. BPSK settings (offset 0, shift 1) on phase 8'hC0 give 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_in | input | 8 | Phase sample, one full turn over the code range |
| phase_vld | input | 1 | Marks `phase_in` and `cfg_in` as a sample to accept |
| cfg_in | input | 6 | Folding control: [3:0] signed offset, [5:4] shift count |
| err_out | output | 8 | Folded phase error, signed two's complement angle |
| err_vld | output | 1 | High for one cycle for each accepted sample |

## Verification
Each folded result is due exactly one rising edge after the edge that accepts its sample, so it is visible at the next falling edge.

The driver applies inputs at a falling edge and, at the same moment, queues the value it computes from the wrapped-turn arithmetic. The monitor samples at each later falling edge. When it sees `err_vld`, it pops one queued value and compares it, which keeps every comparison locked to the one-cycle latency. It also treats a valid output with nothing queued as a failure.

Idle stretches with changing inputs are checked at the falling edges in between, to confirm that the output holds.

// File: rtl/psk_fold_pkg.sv
// Package: shared widths and the control-word layout for the PSK phase folder.
// Assumes an 8-bit phase covering one turn and a 4-bit signed offset that
// lands on the phase's upper nibble.
package psk_fold_pkg;
    parameter int PHASE_W = 8;                  // phase word width, one full turn
    parameter int OFF_W   = 4;                  // offset width (two's complement)
    parameter int SH_W    = 2;                  // shift count width
    localparam int MAX_SH = (1 << SH_W) - 1;    // largest left shift
    localparam int CFG_W  = OFF_W + SH_W;       // total control width

    // Control word: shift count above the offset, matching cfg_in[5:4]/[3:0].
    typedef struct packed {
        logic [SH_W-1:0]  shift;
        logic [OFF_W-1:0] offset;
    } fold_cfg_t;
endpackage

// File: rtl/psk_nibble_rotator.sv
// Module: adds a signed offset to the top OFF_W bits of a phase word.
// Lower bits pass unchanged; the carry out of the top bit is dropped, which
// gives rotation modulo one turn. Purely combinational.
module psk_nibble_rotator #(
    parameter int PHASE_W = 8,
    parameter int OFF_W   = 4
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [OFF_W-1:0]   offset_i,
    output logic [PHASE_W-1:0] rot_o
);
    localparam int LOW_W = PHASE_W - OFF_W;

    logic [OFF_W-1:0] top_sum;

    // Modular add on the upper field; width truncation discards the carry.
    always_comb begin
        top_sum = phase_i[PHASE_W-1:LOW_W] + offset_i;
        rot_o   = {top_sum, phase_i[LOW_W-1:0]};
    end
endmodule

// File: rtl/psk_wrap_shifter.sv
// Module: left shift by 0..2^SH_W-1 places with the top bits discarded.
// Builds one candidate per shift amount and selects one with the count.
// Assumes the count is at most PHASE_W-1. Purely combinational.
module psk_wrap_shifter #(
    parameter int PHASE_W = 8,
    parameter int SH_W    = 2
) (
    input  logic [PHASE_W-1:0] data_i,
    input  logic [SH_W-1:0]    shift_i,
    output logic [PHASE_W-1:0] data_o
);
    localparam int N_SH = 1 << SH_W;

    logic [PHASE_W-1:0] cand [N_SH];

    for (genvar k = 0; k < N_SH; k++) begin : g_cand
        // Candidate for shift k: drop the top k bits, fill k zeros below.
        assign cand[k] = PHASE_W'(data_i << k);
    end

    // Pick the candidate named by the shift count.
    always_comb begin
        data_o = cand[shift_i];
    end
endmodule

// File: rtl/psk_fold_outreg.sv
// Module: output register stage with a valid flag.
// Loads the data on an accepted sample and holds it otherwise. The flag
// follows the input strobe one cycle later. Synchronous active-low reset.
module psk_fold_outreg #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] data_i,
    output logic [PHASE_W-1:0] data_o,
    output logic               vld_o
);
    // Capture the folded value on accept; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= load_i;
            if (load_i) begin
                data_o <= data_i;
            end
        end
    end
endmodule

// File: rtl/psk_phase_folder.sv
// Module: PSK carrier phase error folder (top).
// Rotates each accepted phase sample by the configured offset on its upper
// bits, then multiplies it by 2^shift modulo one turn. The result is a
// registered signed error with one cycle of latency. cfg_in is read only
// alongside a valid sample.
module psk_phase_folder
    import psk_fold_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               phase_vld,
    input  logic [CFG_W-1:0]   cfg_in,
    output logic [PHASE_W-1:0] err_out,
    output logic               err_vld
);
    fold_cfg_t          cfg;
    logic [PHASE_W-1:0] rotated;
    logic [PHASE_W-1:0] folded;

    // Split the control word into its offset and shift fields.
    always_comb begin
        cfg = fold_cfg_t'(cfg_in);
    end

    psk_nibble_rotator #(.PHASE_W(PHASE_W), .OFF_W(OFF_W)) u_rot (
        .phase_i  (phase_in),
        .offset_i (cfg.offset),
        .rot_o    (rotated)
    );

    psk_wrap_shifter #(.PHASE_W(PHASE_W), .SH_W(SH_W)) u_shf (
        .data_i  (rotated),
        .shift_i (cfg.shift),
        .data_o  (folded)
    );

    psk_fold_outreg #(.PHASE_W(PHASE_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (phase_vld),
        .data_i (folded),
        .data_o (err_out),
        .vld_o  (err_vld)
    );
endmodule

// File: rtl/psk_fold_checker.sv
// Module: assertion checker for psk_phase_folder, attached by bind.
// Observes ports only and relates accepted samples to the next cycle's output.
module psk_fold_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] phase_in,
    input logic       phase_vld,
    input logic [5:0] cfg_in,
    input logic [7:0] err_out,
    input logic       err_vld
);
    // R1: reset clears the outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!err_vld && err_out == 8'h00));

    // R2: the valid flag follows the strobe by one cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |=> err_vld);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vld |=> !err_vld);

    // R3: with shift 0 the low nibble passes through the rotation untouched.
    a_r3_low_nibble_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && cfg_in[5:4] == 2'd0) |=> (err_out[3:0] == $past(phase_in[3:0])));

    // R4: shifts fill the low bits with zeros.
    a_r4_shift1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && cfg_in[5:4] == 2'd1) |=> (err_out[0] == 1'b0));
    a_r4_shift2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && cfg_in[5:4] == 2'd2) |=> (err_out[1:0] == 2'b00));
    a_r4_shift3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && cfg_in[5:4] == 2'd3) |=> (err_out[2:0] == 3'b000));

    // R7: without an accepted sample the output holds.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vld |=> $stable(err_out));
endmodule

bind psk_phase_folder psk_fold_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_in  (phase_in),
    .phase_vld (phase_vld),
    .cfg_in    (cfg_in),
    .err_out   (err_out),
    .err_vld   (err_vld)
);

// File: tb/tb_psk_phase_folder.sv
// Scoreboard bench: the driver queues expected results; the monitor pops and
// compares them at falling edges whenever err_vld is high.
module tb_psk_phase_folder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] phase_in = 8'h00;
    logic       phase_vld = 1'b0;
    logic [5:0] cfg_in = 6'h00;
    logic [7:0] err_out;
    logic       err_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] value;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    psk_phase_folder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phase_in),
        .phase_vld (phase_vld),
        .cfg_in    (cfg_in),
        .err_out   (err_out),
        .err_vld   (err_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected value: rotate by offset*22.5 deg, scale by 2^shift, wrap a turn.
    function automatic logic [7:0] model(input logic [7:0] p, input int offs, input int sh);
        int a;
        a = ((int'(p) + 16 * offs + 256) * (1 << sh)) % 256;
        return a[7:0];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one sample at a falling edge and queue its expected result.
    task automatic send(input logic [7:0] p, input int offs, input int sh, input string tag);
        exp_t e;
        @(negedge clk);
        phase_in  = p;
        cfg_in    = {2'(sh), 4'(offs)};
        phase_vld = 1'b1;
        e.value = model(p, offs, sh);
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Idle cycles with changing, ignored inputs.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            phase_vld = 1'b0;
            phase_in  = 8'(37 * i + 11);
            cfg_in    = 6'(13 * i + 5);
        end
    endtask

    // Monitor: compare each valid output against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && err_vld) begin
            if (sb_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R2: actual valid with empty queue, expected no valid");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, err_out, e.value);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 err_out in reset", err_out, 8'h00);
        check("R1 err_vld in reset", {7'b0, err_vld}, 8'h00);
        rst_n = 1'b1;

        // R3: offset only, low nibble kept
        send(8'h3A, 3, 0, "R3 offset +3");
        send(8'hE7, 2, 0, "R3 carry dropped");
        // R5: negative offset wraps
        send(8'h05, -1, 0, "R5 offset -1");
        send(8'h1C, -8, 0, "R5 offset -8");
        // R6: QPSK
        send(8'h60, 2, 2, "R6 qpsk 0x60");
        send(8'h65, 2, 2, "R6 qpsk 0x65");
        // R8: BPSK gives -180 code
        send(8'hC0, 0, 1, "R8 bpsk 0xC0");
        // R4: 8-PSK, shift 3
        send(8'hB3, 1, 3, "R4 8psk");
        send(8'hFF, 7, 3, "R4 shift3 max");
        // R2: gap between samples
        idle(1);
        phase_vld = 1'b0;
        @(negedge clk);
        check("R2 no valid after idle", {7'b0, err_vld}, 8'h00);

        // R7: output holds while cfg/phase change without strobe
        send(8'h47, 5, 1, "R7 before hold");
        idle(1);
        held = model(8'h47, 5, 1);
        idle(4);
        check("R7 hold after idle", err_out, held);
        check("R7 no valid while idle", {7'b0, err_vld}, 8'h00);

        // R6: QPSK sweep of all phases
        for (int p = 0; p < 256; p++) begin
            send(8'(p), 2, 2, "R6 qpsk sweep");
        end
        // R4: shift sweep over a few offsets
        for (int s = 0; s < 4; s++) begin
            for (int o = -8; o < 8; o += 3) begin
                send(8'(29 * (o + 8) + s), o, s, "R4 sweep");
            end
        end
        idle(3);
        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: actual %0d pending expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule